// File: doc/BRIEF.md
# Conditional EEPROM Download Executor

This block replays a stored instruction stream from a byte-wide EEPROM read port into the device-settings register map. It starts at EEPROM address zero, reads one byte at a time and decodes each byte as an instruction. A data instruction carries a byte count. It is followed by a two-byte register address, the data bytes and a checksum byte. Each data byte is written through a simple register write port to consecutive addresses. Condition instructions set a tag that decides whether the data blocks after it take effect. A block is applied only when the tag is clear or equals the active condition chosen for this download.

A download starts in one of two ways. After a hard reset or a soft reset, it starts by itself if the 5-bit strap input is nonzero. At any idle time it starts on a one-cycle load command. In both cases the strap value, sampled when the download starts, becomes the active condition. The block reports busy, a one-cycle done pulse and a sticky checksum-error flag.

Top module: `eedl_exec`

## Requirements
- R1: After reset with a zero strap value, the block stays idle: busy, done and checksum error are low, and no EEPROM read and no register write occurs.
- R2: On leaving a hard reset with a nonzero strap value, a download starts without a command, and the strap value becomes the active condition.
- R3: A high load input while idle starts a download whose first EEPROM read is at address 0. A load input while busy has no effect.
- R4: A byte 0x00–0x7F is a data instruction with count = byte + 1. It is followed by the high address byte, the low address byte, count data bytes and one checksum byte. Data byte i goes to register address + i, in order.
- R5: A byte 0x80–0x9F is a condition instruction: its low five bits become the current tag, and 0x80 clears it. The tag is clear when a download starts, and condition instructions always execute.
- R6: A data block is written only when the current tag is clear or equals the active condition. Otherwise its bytes are read and dropped, and decoding resumes after its checksum.
- R7: The pause byte 0xA0 and every other byte 0xA1–0xFE read in instruction position are skipped without effect.
- R8: The end byte 0xFF ends the download. busy falls and done is high for exactly one cycle on the same edge.
- R9: The checksum byte must equal the 8-bit sum, modulo 256, of the block's data bytes. A mismatch, in applied or skipped blocks, sets the checksum-error flag without stopping execution. The flag holds until the next download starts or a reset occurs.
- R10: A soft-reset pulse aborts a running download without done. It then restarts the download if the strap value is nonzero.
- R11: EEPROM reads happen only while busy, never in two consecutive cycles, with an address that rises by one per read. The data is taken one cycle after each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard/power-up reset |
| soft_rst_i | input | 1 | Synchronous soft reset pulse |
| load_i | input | 1 | Download command pulse |
| strap_cond_i | input | COND_W | Startup condition value |
| rom_rd_o | output | 1 | EEPROM byte read strobe |
| rom_addr_o | output | ROM_AW | EEPROM byte address |
| rom_data_i | input | 8 | EEPROM byte, valid the cycle after the strobe |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | REG_AW | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| busy_o | output | 1 | Download in progress |
| done_o | output | 1 | One-cycle pulse when a download completes |
| cksum_err_o | output | 1 | Sticky checksum mismatch flag |

## Verification
A decoder that loses its place in the stream shows up at once. The next register write then has the wrong address or data, or a write appears where none is expected. The executor reads a new byte every second cycle, so the slip shows within a few cycles. A tag register stuck or loaded with the wrong bits shows as a missing or extra write at the first conditioned block. A wrong checksum sum shows on the error flag after the block's last byte. A broken start or end path shows as a first read address other than zero, a done pulse that is missing or doubled, or busy staying high until the watchdog expires.

// File: rtl/eedl_pkg.sv
package eedl_pkg;
   localparam int OPW = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_AHI,
      ST_ALO,
      ST_DAT,
      ST_CKS
   } eedl_st_e;

   localparam logic [OPW-1:0] OP_END = 8'hFF;

   function automatic logic op_is_data(input logic [OPW-1:0] b);
      return !b[OPW-1];
   endfunction

   function automatic logic op_is_cond(input logic [OPW-1:0] b);
      return b[OPW-1 -: 3] == 3'b100;
   endfunction
endpackage

// File: rtl/eedl_cond_gate.sv
module eedl_cond_gate #(
   parameter int COND_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              load_i,
   input  logic [COND_W-1:0] tag_i,
   input  logic [COND_W-1:0] act_i,
   output logic              pass_o
);
   logic [COND_W-1:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q <= '0;
      else if (clr_i)  tag_q <= '0;
      else if (load_i) tag_q <= tag_i;
   end

   assign pass_o = (tag_q == '0) || (tag_q == act_i);
endmodule

// File: rtl/eedl_cksum.sv
module eedl_cksum #(
   parameter int DW        = 8,
   parameter bit USE_XOR   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          add_i,
   input  logic [DW-1:0] byte_i,
   output logic [DW-1:0] sum_o
);
   logic [DW-1:0] nxt;

   generate
      if (USE_XOR) begin : g_xor
         assign nxt = sum_o ^ byte_i;
      end else begin : g_add
         assign nxt = sum_o + byte_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_o <= '0;
      else if (clr_i) sum_o <= '0;
      else if (add_i) sum_o <= nxt;
   end
endmodule

// File: rtl/eedl_exec.sv
module eedl_exec #(
   parameter int ROM_AW    = 11,
   parameter int REG_AW    = 16,
   parameter int COND_W    = 5,
   parameter bit CKSUM_XOR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              load_i,
   input  logic [COND_W-1:0] strap_cond_i,
   output logic              rom_rd_o,
   output logic [ROM_AW-1:0] rom_addr_o,
   input  logic [7:0]        rom_data_i,
   output logic              reg_we_o,
   output logic [REG_AW-1:0] reg_addr_o,
   output logic [7:0]        reg_wdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              cksum_err_o
);
   import eedl_pkg::*;

   localparam int LEN_W = OPW - 1;

   generate
      if (REG_AW < OPW || REG_AW > 2 * OPW) begin : g_bad_reg_aw
         $error("REG_AW must lie between one and two address bytes");
      end
      if (COND_W < 1 || COND_W > 5) begin : g_bad_cond_w
         $error("COND_W must lie between 1 and 5");
      end
      if (ROM_AW < 2) begin : g_bad_rom_aw
         $error("ROM_AW too small");
      end
   endgenerate

   eedl_st_e          st;
   logic              pend, boot_q, err_q, done_q, we_q;
   logic [ROM_AW-1:0] ptr;
   logic [COND_W-1:0] act;
   logic [LEN_W-1:0]  left;
   logic [OPW-1:0]    ahi;
   logic [REG_AW-1:0] base, wa_q;
   logic [OPW-1:0]    wd_q;
   logic              launch, take, pass, cks_clr, cks_add, tag_ld;
   logic [OPW-1:0]    sum;

   assign launch  = (st == ST_IDLE) && ((boot_q && (strap_cond_i != '0)) || load_i);
   assign take    = pend && (st != ST_IDLE);
   assign cks_clr = launch || (take && st == ST_ALO);
   assign cks_add = take && (st == ST_DAT);
   assign tag_ld  = take && (st == ST_OPC) && op_is_cond(rom_data_i);

   eedl_cond_gate #(.COND_W(COND_W)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (launch),
      .load_i (tag_ld),
      .tag_i  (rom_data_i[COND_W-1:0]),
      .act_i  (act),
      .pass_o (pass)
   );

   eedl_cksum #(.DW(OPW), .USE_XOR(CKSUM_XOR)) u_cks (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cks_clr),
      .add_i  (cks_add),
      .byte_i (rom_data_i),
      .sum_o  (sum)
   );

   assign rom_rd_o   = (st != ST_IDLE) && !pend;
   assign rom_addr_o = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         pend   <= 1'b0;
         boot_q <= 1'b1;
         err_q  <= 1'b0;
         done_q <= 1'b0;
         we_q   <= 1'b0;
         ptr    <= '0;
         act    <= '0;
         left   <= '0;
         ahi    <= '0;
         base   <= '0;
         wa_q   <= '0;
         wd_q   <= '0;
      end else if (soft_rst_i) begin
         st     <= ST_IDLE;
         pend   <= 1'b0;
         boot_q <= 1'b1;
         err_q  <= 1'b0;
         done_q <= 1'b0;
         we_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         we_q   <= 1'b0;
         if (rom_rd_o) begin
            pend <= 1'b1;
            ptr  <= ptr + 1'b1;
         end
         if (st == ST_IDLE) begin
            boot_q <= 1'b0;
            if (launch) begin
               st    <= ST_OPC;
               ptr   <= '0;
               act   <= strap_cond_i;
               err_q <= 1'b0;
            end
         end else if (take) begin
            pend <= 1'b0;
            unique case (st)
               ST_OPC: begin
                  if (op_is_data(rom_data_i)) begin
                     left <= rom_data_i[LEN_W-1:0];
                     st   <= ST_AHI;
                  end else if (rom_data_i == OP_END) begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
               ST_AHI: begin
                  ahi <= rom_data_i;
                  st  <= ST_ALO;
               end
               ST_ALO: begin
                  base <= REG_AW'({ahi, rom_data_i});
                  st   <= ST_DAT;
               end
               ST_DAT: begin
                  if (pass) begin
                     we_q <= 1'b1;
                     wa_q <= base;
                     wd_q <= rom_data_i;
                  end
                  base <= base + 1'b1;
                  if (left == '0) st <= ST_CKS;
                  else            left <= left - 1'b1;
               end
               ST_CKS: begin
                  if (rom_data_i != sum) err_q <= 1'b1;
                  st <= ST_OPC;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign reg_we_o    = we_q;
   assign reg_addr_o  = wa_q;
   assign reg_wdata_o = wd_q;
   assign busy_o      = (st != ST_IDLE);
   assign done_o      = done_q;
   assign cksum_err_o = err_q;
endmodule

// File: rtl/eedl_exec_chk.sv
module eedl_exec_chk #(
   parameter int ROM_AW = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              rom_rd_o,
   input logic [ROM_AW-1:0] rom_addr_o,
   input logic              reg_we_o,
   input logic              cksum_err_o
);
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
      $rose(done_o) |-> $past(busy_o));

   assert_rd_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd_o |=> !rom_rd_o);

   assert_rd_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd_o |-> busy_o);

   assert_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd_o && $rose(busy_o)) |-> (rom_addr_o == '0));

   assert_we_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o |-> busy_o);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
      cksum_err_o |=> (cksum_err_o || $rose(busy_o)));
endmodule

bind eedl_exec eedl_exec_chk #(.ROM_AW(ROM_AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .soft_rst_i  (soft_rst_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .rom_rd_o    (rom_rd_o),
   .rom_addr_o  (rom_addr_o),
   .reg_we_o    (reg_we_o),
   .cksum_err_o (cksum_err_o)
);

// File: tb/sim_eedl_exec.sv
`timescale 1ns/1ps
module sim_eedl_exec;
   localparam int ROM_AW = 11;
   localparam int REG_AW = 16;
   localparam int COND_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              soft_rst_i = 1'b0;
   logic              load_i = 1'b0;
   logic [COND_W-1:0] strap_cond_i = '0;
   logic              rom_rd_o;
   logic [ROM_AW-1:0] rom_addr_o;
   logic [7:0]        rom_data_i = '0;
   logic              reg_we_o;
   logic [REG_AW-1:0] reg_addr_o;
   logic [7:0]        reg_wdata_o;
   logic              busy_o, done_o, cksum_err_o;

   int n_cmp = 0;
   int n_bad = 0;
   int done_cnt = 0;
   int cyc = 0;
   logic [ROM_AW-1:0] exp_ptr = '0;
   logic prev_done = 1'b0;
   logic [23:0] expq[$];
   logic [7:0]  mem [0:(1<<ROM_AW)-1];

   always #4 clk = ~clk;

   eedl_exec #(.ROM_AW(ROM_AW), .REG_AW(REG_AW), .COND_W(COND_W)) u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .load_i(load_i),
      .strap_cond_i(strap_cond_i), .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o),
      .rom_data_i(rom_data_i), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
      .reg_wdata_o(reg_wdata_o), .busy_o(busy_o), .done_o(done_o),
      .cksum_err_o(cksum_err_o)
   );

   // EEPROM model: byte valid one cycle after the strobe (R11)
   always @(posedge clk) if (rom_rd_o) rom_data_i <= mem[rom_addr_o];

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push_exp(input logic [15:0] a, input logic [7:0] d);
      expq.push_back({a, d});
   endtask

   // monitor: register writes, done pulses, read addresses
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we_o) begin
            if (expq.size() == 0) chk(1'b0, "R6 unexpected write", int'({reg_addr_o, reg_wdata_o}), 0);
            else begin
               logic [23:0] e;
               e = expq.pop_front();
               chk({reg_addr_o, reg_wdata_o} == e, "R4 write addr/data", int'({reg_addr_o, reg_wdata_o}), int'(e));
            end
         end
         if (done_o) begin
            done_cnt++;
            chk(!busy_o, "R8 busy low at done", int'(busy_o), 0);
            chk(!prev_done, "R8 done single cycle", int'(prev_done), 0);
         end
         prev_done = done_o;
         if (rom_rd_o) begin
            chk(rom_addr_o == exp_ptr, "R11 read address", int'(rom_addr_o), int'(exp_ptr));
            exp_ptr = exp_ptr + 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 40000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic put(input int a, input logic [7:0] b);
      mem[a] = b;
   endtask

   task automatic prog1();
      for (int i = 0; i < (1<<ROM_AW); i++) mem[i] = 8'hFF;
      put(0, 8'hA0);                                   // pause, skipped (R7)
      put(1, 8'h01); put(2, 8'h01); put(3, 8'h20);     // 2 bytes to 0x0120, tag clear
      put(4, 8'h11); put(5, 8'h22); put(6, 8'h33);
      put(7, 8'h85);                                   // tag 5
      put(8, 8'h00); put(9, 8'h02); put(10, 8'h00);
      put(11, 8'h55); put(12, 8'h55);
      put(13, 8'h83);                                  // tag 3
      put(14, 8'h00); put(15, 8'h03); put(16, 8'h00);
      put(17, 8'h77); put(18, 8'h00);                  // bad checksum (R9)
      put(19, 8'h80);                                  // clear tag
      put(20, 8'hC4);                                  // unknown, skipped (R7)
      put(21, 8'h00); put(22, 8'h00); put(23, 8'h10);
      put(24, 8'h9A); put(25, 8'h9A);
      put(26, 8'hFF);                                  // end (R8)
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done_o && n < 2000) begin @(negedge clk); n++; end
      chk(done_o, "R8 done reached", int'(done_o), 1);
      @(negedge clk);
   endtask

   initial begin
      prog1();
      // R1: idle after reset with zero strap
      strap_cond_i = 5'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o, "R1 busy", int'(busy_o), 0);
      chk(!done_o, "R1 done", int'(done_o), 0);
      chk(!cksum_err_o, "R1 cksum_err", int'(cksum_err_o), 0);
      begin
         int rd_seen = 0;
         repeat (12) begin @(negedge clk); if (rom_rd_o || busy_o) rd_seen++; end
         chk(rd_seen == 0, "R1 no activity", rd_seen, 0);
      end

      // R2: hard reset with strap 3 launches; tag 3 block applied, tag 5 skipped (R5, R6)
      strap_cond_i = 5'd3;
      rst_n = 1'b0;
      @(negedge clk);
      exp_ptr = '0;
      push_exp(16'h0120, 8'h11); push_exp(16'h0121, 8'h22);
      push_exp(16'h0300, 8'h77); push_exp(16'h0010, 8'h9A);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(busy_o, "R2 auto launch busy", int'(busy_o), 1);
      wait_done();
      chk(cksum_err_o, "R9 error after bad block", int'(cksum_err_o), 1);
      chk(expq.size() == 0, "R4 all writes seen", expq.size(), 0);
      chk(done_cnt == 1, "R8 one done", done_cnt, 1);

      // R3: manual load with condition 5, error flag cleared at start, load while busy ignored
      put(18, 8'h77);
      strap_cond_i = 5'd5;
      exp_ptr = '0;
      push_exp(16'h0120, 8'h11); push_exp(16'h0121, 8'h22);
      push_exp(16'h0200, 8'h55); push_exp(16'h0010, 8'h9A);
      load_i = 1'b1; @(negedge clk); load_i = 1'b0;
      chk(busy_o, "R3 manual start", int'(busy_o), 1);
      chk(!cksum_err_o, "R9 flag cleared on start", int'(cksum_err_o), 0);
      repeat (6) @(negedge clk);
      load_i = 1'b1; @(negedge clk); load_i = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      chk(!busy_o, "R3 load while busy ignored", int'(busy_o), 0);
      chk(done_cnt == 2, "R3 no second run", done_cnt, 2);
      chk(!cksum_err_o, "R9 no error on good blocks", int'(cksum_err_o), 0);
      chk(expq.size() == 0, "R6 writes of run 2", expq.size(), 0);

      // R10: soft reset aborts without done, zero strap leaves idle
      strap_cond_i = 5'd0;
      exp_ptr = '0;
      load_i = 1'b1; @(negedge clk); load_i = 1'b0;
      repeat (4) @(negedge clk);
      soft_rst_i = 1'b1; @(negedge clk); soft_rst_i = 1'b0;
      repeat (20) @(negedge clk);
      chk(!busy_o, "R10 aborted", int'(busy_o), 0);
      chk(done_cnt == 2, "R10 no done on abort", done_cnt, 2);

      // R10: soft reset with strap 3 relaunches
      strap_cond_i = 5'd3;
      exp_ptr = '0;
      push_exp(16'h0120, 8'h11); push_exp(16'h0121, 8'h22);
      push_exp(16'h0300, 8'h77); push_exp(16'h0010, 8'h9A);
      soft_rst_i = 1'b1; @(negedge clk); soft_rst_i = 1'b0;
      @(negedge clk);
      chk(busy_o, "R10 relaunch", int'(busy_o), 1);
      wait_done();
      chk(expq.size() == 0, "R5 writes of run 3", expq.size(), 0);
      chk(!cksum_err_o, "R9 clean run", int'(cksum_err_o), 0);
      chk(done_cnt == 3, "R8 third done", done_cnt, 3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule